// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Control

This block is the combinational control logic for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the register numbers of the instruction in execute against the destinations held in the two later pipeline registers. It then picks, for each ALU operand, whether the value comes from the register file, from the memory-stage register or from the writeback-stage register.

It also detects a load whose result the decode-stage instruction needs at once. For that case it holds the program counter and the fetch/decode register for one cycle and turns the decode/execute entry into a bubble. After the stall, the value arrives through the writeback forwarding path. When a branch resolves against the fetched path, the block flushes the two younger instructions so fetch can be redirected. That flush overrides any stall requested in the same cycle. All other dependencies are handled by forwarding alone, without a stall.

Top module: `pipe_hazard_unit`

## Requirements
- R1: An operand select is 2'b10 (memory-stage value) when the memory-stage instruction writes a nonzero destination equal to that operand's execute-stage source.
- R2: An operand select is 2'b01 (writeback-stage value) when the writeback-stage instruction writes a nonzero destination equal to that source and the memory stage does not match.
- R3: When both later stages match the same source, the memory stage wins (2'b10).
- R4: A source of register 0 always selects 2'b00 (register file), whatever the later stages hold.
- R5: A stage whose write enable is low never supplies a forward. With no match, the select is 2'b00.
- R6: A load in execute whose nonzero destination equals a used decode-stage source raises pc_hold_o, ifid_hold_o and idex_bubble_o together.
- R7: A decode-stage source marked unused never causes a stall, even when its number matches the load destination.
- R8: No stall is raised for a non-load in execute, for a load targeting register 0, or for a load with no matching source.
- R9: A branch redirect raises ifid_flush_o and idex_flush_o and suppresses pc_hold_o, ifid_hold_o and idex_bubble_o in the same cycle.
- R10: Without a redirect, both flush outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | REG_AW | First source of the decode-stage instruction |
| id_rs2_i | input | REG_AW | Second source of the decode-stage instruction |
| id_use_rs1_i | input | 1 | Decode-stage instruction reads its first source |
| id_use_rs2_i | input | 1 | Decode-stage instruction reads its second source |
| ex_rs1_i | input | REG_AW | First source of the execute-stage instruction |
| ex_rs2_i | input | REG_AW | Second source of the execute-stage instruction |
| ex_rd_i | input | REG_AW | Destination of the execute-stage instruction |
| ex_is_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | REG_AW | Destination held in the memory-stage register |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| wb_rd_i | input | REG_AW | Destination held in the writeback-stage register |
| wb_we_i | input | 1 | Writeback-stage instruction writes a register |
| br_redirect_i | input | 1 | Branch resolved against the fetched path |
| fwd_a_o | output | 2 | Select for ALU operand A |
| fwd_b_o | output | 2 | Select for ALU operand B |
| pc_hold_o | output | 1 | Keep the program counter |
| ifid_hold_o | output | 1 | Keep the fetch/decode register |
| idex_bubble_o | output | 1 | Load a bubble into decode/execute |
| ifid_flush_o | output | 1 | Clear the fetch/decode register |
| idex_flush_o | output | 1 | Clear the decode/execute register |

## Verification
The hardest case to reach is the collision of three conditions in one cycle: a load-use match, a double match on an execute source, and a branch redirect. That is where stall, forwarding priority and flush priority interact. Directed vectors build it explicitly. After that, a long random run draws register numbers from only four values, so that matches, register-0 sources and simultaneous matches occur often. A behavioural model checks every output on every cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  output fwd_sel_e          sel_o
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic src_live, mem_hit, wb_hit;

  assign src_live = (src_i != ZERO_REG);
  assign mem_hit  = src_live && mem_we_i && (mem_rd_i == src_i);
  assign wb_hit   = src_live && wb_we_i  && (wb_rd_i  == src_i);

  always_comb begin
    if (mem_hit)     sel_o = FWD_MEM;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end

  always_comb begin
    a_r4_zero_src: assert (src_i != ZERO_REG || sel_o == FWD_RF);
    a_r3_mem_first: assert (!(mem_we_i && mem_rd_i == src_i && src_i != ZERO_REG) || sel_o == FWD_MEM);
    a_r5_legal_code: assert (sel_o != 2'b11);
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_use_rs1_i,
  input  logic              id_use_rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_is_load_i,
  output logic              stall_o
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic dst_live, hit1, hit2;

  assign dst_live = ex_is_load_i && (ex_rd_i != ZERO_REG);
  assign hit1     = id_use_rs1_i && (id_rs1_i == ex_rd_i);
  assign hit2     = id_use_rs2_i && (id_rs2_i == ex_rd_i);
  assign stall_o  = dst_live && (hit1 || hit2);

  always_comb begin
    a_r7_unused_src: assert (id_use_rs1_i || id_use_rs2_i || !stall_o);
    a_r8_load_only: assert (ex_is_load_i || !stall_o);
  end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_use_rs1_i,
  input  logic              id_use_rs2_i,
  input  logic [REG_AW-1:0] ex_rs1_i,
  input  logic [REG_AW-1:0] ex_rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_is_load_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  input  logic              br_redirect_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              pc_hold_o,
  output logic              ifid_hold_o,
  output logic              idex_bubble_o,
  output logic              ifid_flush_o,
  output logic              idex_flush_o
);
  localparam int N_OPS = 2;

  logic [REG_AW-1:0] ex_src [N_OPS];
  fwd_sel_e          sel    [N_OPS];
  logic              lu_stall, stall_eff;

  assign ex_src[0] = ex_rs1_i;
  assign ex_src[1] = ex_rs2_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    hz_fwd_sel #(.REG_AW(REG_AW)) u_fwd (
      .src_i    (ex_src[g]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (sel[g])
    );
  end

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];

  hz_load_use #(.REG_AW(REG_AW)) u_lu (
    .id_rs1_i     (id_rs1_i),
    .id_rs2_i     (id_rs2_i),
    .id_use_rs1_i (id_use_rs1_i),
    .id_use_rs2_i (id_use_rs2_i),
    .ex_rd_i      (ex_rd_i),
    .ex_is_load_i (ex_is_load_i),
    .stall_o      (lu_stall)
  );

  // flush overrides the interlock
  assign stall_eff     = lu_stall && !br_redirect_i;
  assign pc_hold_o     = stall_eff;
  assign ifid_hold_o   = stall_eff;
  assign idex_bubble_o = stall_eff;
  assign ifid_flush_o  = br_redirect_i;
  assign idex_flush_o  = br_redirect_i;

  always_comb begin
    a_r9_flush_wins: assert (!ifid_flush_o || (!pc_hold_o && !idex_bubble_o && idex_flush_o));
    a_r6_hold_group: assert (pc_hold_o == ifid_hold_o && ifid_hold_o == idex_bubble_o);
    a_r10_quiet: assert (br_redirect_i || (!ifid_flush_o && !idex_flush_o));
  end
endmodule

// File: tb/pipe_hazard_unit_test.sv
module pipe_hazard_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  logic clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_u1, id_u2, ex_ld, mem_we, wb_we, redir;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, bubble, ifid_flush, idex_flush;
  int checks = 0, errors = 0;

  pipe_hazard_unit #(.REG_AW(AW)) uut (
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_use_rs1_i(id_u1), .id_use_rs2_i(id_u2),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd), .ex_is_load_i(ex_ld),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .br_redirect_i(redir),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold),
    .idex_bubble_o(bubble), .ifid_flush_o(ifid_flush), .idex_flush_o(idex_flush)
  );

  function automatic int exp_fwd(int src);
    if (src == 0) return 0;
    if (mem_we && int'(mem_rd) == src) return 2;
    if (wb_we && int'(wb_rd) == src) return 1;
    return 0;
  endfunction

  function automatic string fwd_tag(int src);
    if (src == 0) return "R4";
    if (mem_we && int'(mem_rd) == src && wb_we && int'(wb_rd) == src) return "R3";
    if (mem_we && int'(mem_rd) == src) return "R1";
    if (wb_we && int'(wb_rd) == src) return "R2";
    return "R5";
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // compare every output against the behavioural model
  task automatic check_all(string stall_tag);
    bit lu, st;
    string st_tag;
    lu = ex_ld && ex_rd != 0 && ((id_u1 && id_rs1 == ex_rd) || (id_u2 && id_rs2 == ex_rd));
    st = lu && !redir;
    st_tag = redir ? "R9" : (stall_tag != "" ? stall_tag : (lu ? "R6" : "R8"));
    cmp(fwd_tag(int'(ex_rs1)), "fwd_a", int'(fwd_a), exp_fwd(int'(ex_rs1)));
    cmp(fwd_tag(int'(ex_rs2)), "fwd_b", int'(fwd_b), exp_fwd(int'(ex_rs2)));
    cmp(st_tag, "pc_hold", int'(pc_hold), int'(st));
    cmp(st_tag, "ifid_hold", int'(ifid_hold), int'(st));
    cmp(st_tag, "idex_bubble", int'(bubble), int'(st));
    cmp(redir ? "R9" : "R10", "ifid_flush", int'(ifid_flush), int'(redir));
    cmp(redir ? "R9" : "R10", "idex_flush", int'(idex_flush), int'(redir));
  endtask

  task automatic drive(int a1, int a2, bit u1, bit u2, int e1, int e2, int erd, bit ld,
                       int mrd, bit mwe, int wrd, bit wwe, bit rd, string tag);
    @(posedge clk); #1;
    id_rs1 = AW'(a1); id_rs2 = AW'(a2); id_u1 = u1; id_u2 = u2;
    ex_rs1 = AW'(e1); ex_rs2 = AW'(e2); ex_rd = AW'(erd); ex_ld = ld;
    mem_rd = AW'(mrd); mem_we = mwe; wb_rd = AW'(wrd); wb_we = wwe; redir = rd;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    id_rs1 = 0; id_rs2 = 0; id_u1 = 0; id_u2 = 0; ex_rs1 = 0; ex_rs2 = 0;
    ex_rd = 0; ex_ld = 0; mem_rd = 0; mem_we = 0; wb_rd = 0; wb_we = 0; redir = 0;
    @(negedge clk);
    check_all("R8");                                               // idle state
    drive(0,0,0,0, 3,4, 0,0, 3,1, 9,1, 0, "");                      // R1 on a
    drive(0,0,0,0, 5,7, 0,0, 9,1, 7,1, 0, "");                      // R2 on b
    drive(0,0,0,0, 6,6, 0,0, 6,1, 6,1, 0, "");                      // R3 both
    drive(0,0,0,0, 0,0, 0,0, 0,1, 0,1, 0, "");                      // R4 x0
    drive(0,0,0,0, 8,8, 0,0, 8,0, 8,0, 0, "");                      // R5 we low
    drive(2,0,1,1, 0,0, 2,1, 0,0, 0,0, 0, "R6");                    // R6 rs1
    drive(0,2,1,1, 0,0, 2,1, 0,0, 0,0, 0, "R6");                    // R6 rs2
    drive(2,2,0,0, 0,0, 2,1, 0,0, 0,0, 0, "R7");                    // R7 unused
    drive(3,2,1,0, 0,0, 2,1, 0,0, 0,0, 0, "R7");                    // R7 rs2 unused
    drive(2,2,1,1, 0,0, 2,0, 0,0, 0,0, 0, "R8");                    // R8 non-load
    drive(0,0,1,1, 0,0, 0,1, 0,0, 0,0, 0, "R8");                    // R8 load to x0
    drive(2,2,1,1, 6,6, 2,1, 6,1, 6,1, 1, "R9");                    // R9 flush over stall
    drive(1,1,1,1, 1,1, 1,1, 1,1, 1,1, 0, "");                      // R6 + R3 together
    for (int i = 0; i < 3000; i++) begin
      drive($urandom_range(0,3), $urandom_range(0,3), 1'($urandom), 1'($urandom),
            $urandom_range(0,3), $urandom_range(0,3), $urandom_range(0,3), 1'($urandom),
            $urandom_range(0,3), 1'($urandom), $urandom_range(0,3), 1'($urandom),
            ($urandom_range(0,7) == 0), "");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule